// File: doc/BRIEF.md
# I2C Master Stop-Condition Controller

This block is the part of an I2C master that ends a transfer with a stop condition. Software writes a stop request bit through a simple register-write strobe. The block decides whether the request may take effect, using the current wait phase and the transfer direction. Once it accepts a request, it drives the open-drain SCL and SDA pull-down enables through the stop sequence. SDA is held low, SCL is released, the block waits a programmable hold time after SCL is seen high, and then SDA is released.

The request only takes effect while the interface is enabled and working as bus master. It has to arrive in a wait phase that suits the direction of the transfer, and it cannot arrive together with a start request. A pending request clears itself when arbitration is lost, when any stop condition is seen on the bus, on a release command, or when the interface is disabled. A separate detector watches the synchronized bus lines. It pulses for one cycle whenever a stop condition appears, whether this block or some other master produced it. Start generation, byte shifting and address matching belong to neighbouring blocks.

Top module: `i2c_stop_ctl`

## Requirements
- R1: A stop write (`wr_en`=1, `wr_stop`=1) sets `stop_pend` at the next clock edge only if `en`=1 and `is_master`=1. Otherwise `stop_pend` stays 0.
- R2: A stop write that carries `wr_start`=1 in the same strobe is rejected, and `stop_pend` stays 0.
- R3: In transmission (`is_tx`=1), a stop write is accepted only while `wait9_ph`=1, which is the wait after the ninth clock. It is not accepted during the wait after the eighth clock.
- R4: In reception (`is_tx`=0), a stop write is accepted only when `ack_en`=0 and `last_byte`=1, and at least one of these holds: `wait9_ph`=1, or `wait8_ph`=1 with `wait_sel9`=0 (wait placed after eight clocks).
- R5: A stop write while `stop_pend` is already 1 has no effect. The running sequence keeps its timing.
- R6: `stop_pend` returns to 0 at the clock edge after any of these: `arb_lost`=1, `stop_det`=1, a write with `wr_release`=1, or `en`=0. Arbitration loss, release and disable also drop both pull enables at that edge.
- R7: At the edge that accepts a request, `sda_pull` and `scl_pull` both become 1. At the next edge `scl_pull` becomes 0 while `sda_pull` stays 1.
- R8: `sda_pull` falls at the (HOLD_CLKS+3)-th rising clock edge after the SCL line rises. While another device stretches SCL low, `sda_pull` stays 1.
- R9: `stop_det` is a one-cycle pulse. It is high in the second cycle after SDA rises while SCL is high, and this holds for a stop from any master.
- R10: While reset is held, `scl_pull`, `sda_pull`, `stop_pend` and `stop_det` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_stop | input | 1 | Stop request bit of the write |
| wr_start | input | 1 | Start request bit of the write |
| wr_release | input | 1 | Communication-release command bit of the write |
| en | input | 1 | Interface enable level |
| wait_sel9 | input | 1 | Wait placement: 1 after nine clocks, 0 after eight |
| ack_en | input | 1 | Acknowledge generation enabled |
| is_master | input | 1 | Interface currently owns the bus as master |
| is_tx | input | 1 | Current transfer direction is transmit |
| arb_lost | input | 1 | Arbitration-loss event |
| wait8_ph | input | 1 | Shifter is in the wait after the eighth clock |
| wait9_ph | input | 1 | Shifter is in the wait after the ninth clock |
| last_byte | input | 1 | Final received byte has been signalled |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| stop_pend | output | 1 | Stop request pending |
| stop_det | output | 1 | One-cycle pulse on a detected stop condition |

## Verification
Suppose the request flag is wrong. A write that should have been rejected then shows up one edge later as `stop_pend` high with both pull enables asserted. A missed clear event shows up as `stop_pend` still high one edge after that event. A sequencer that leaves its state early or late moves the fall of `sda_pull` away from the (HOLD_CLKS+3)-th edge after SCL rises, and a stretched SCL shows this plainly. A faulty edge detector gives a `stop_det` pulse of the wrong length or at the wrong cycle. Because the pending flag clears on the detected stop, such a fault also holds `stop_pend` high past its expected edge.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SDA_LOW,
    SQ_SCL_REL,
    SQ_HOLD,
    SQ_SDA_REL
  } seq_state_t;

  // Wait-phase rule for honouring a stop request.
  function automatic logic stop_window_ok(input logic tx, input logic w8,
                                          input logic w9, input logic after9,
                                          input logic ack, input logic last);
    logic rx_phase;
    rx_phase = w9 | (w8 & ~after9);
    if (tx) return w9;
    return rx_phase & ~ack & last;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_stop_req.sv
module i2c_stop_req
  import i2c_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_stop,
  input  logic wr_start,
  input  logic wr_release,
  input  logic en,
  input  logic wait_sel9,
  input  logic ack_en,
  input  logic is_master,
  input  logic is_tx,
  input  logic arb_lost,
  input  logic wait8_ph,
  input  logic wait9_ph,
  input  logic last_byte,
  input  logic bus_stop,
  output logic accept_ok,
  output logic clr_evt,
  output logic go,
  output logic pend
);
  logic window;

  assign window    = stop_window_ok(is_tx, wait8_ph, wait9_ph, wait_sel9, ack_en, last_byte);
  assign accept_ok = wr_en & wr_stop & ~wr_start & en & is_master & ~pend & window;
  assign clr_evt   = arb_lost | bus_stop | (wr_en & wr_release) | ~en;
  assign go        = accept_ok & ~clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (clr_evt) pend <= 1'b0;
    else if (go)      pend <= 1'b1;
  end
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int HOLD_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic abort,
  input  logic scl_hi,
  output logic hold_done,
  output logic scl_pull,
  output logic sda_pull
);
  localparam int CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_CLKS - 1);

  seq_state_t state, state_n;
  logic [CW-1:0] cnt;

  assign hold_done = (state == SQ_HOLD) && (cnt == LAST_CNT);

  always_comb begin
    state_n = state;
    unique case (state)
      SQ_IDLE:    if (go) state_n = SQ_SDA_LOW;
      SQ_SDA_LOW: state_n = SQ_SCL_REL;
      SQ_SCL_REL: if (scl_hi) state_n = SQ_HOLD;
      SQ_HOLD:    if (hold_done) state_n = SQ_SDA_REL;
      SQ_SDA_REL: state_n = SQ_SDA_REL;
      default:    state_n = SQ_IDLE;
    endcase
    if (abort) state_n = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      if (state == SQ_HOLD) cnt <= cnt + 1'b1;
      else                  cnt <= '0;
    end
  end

  assign scl_pull = (state == SQ_SDA_LOW);
  assign sda_pull = (state == SQ_SDA_LOW) || (state == SQ_SCL_REL) || (state == SQ_HOLD);
endmodule

// File: rtl/i2c_stop_detect.sv
module i2c_stop_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic det
);
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b1;
    else        sda_prev <= sda_s;
  end

  assign det = scl_s & sda_s & ~sda_prev;
endmodule

// File: rtl/i2c_stop_ctl.sv
module i2c_stop_ctl #(
  parameter int HOLD_CLKS   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_stop,
  input  logic wr_start,
  input  logic wr_release,
  input  logic en,
  input  logic wait_sel9,
  input  logic ack_en,
  input  logic is_master,
  input  logic is_tx,
  input  logic arb_lost,
  input  logic wait8_ph,
  input  logic wait9_ph,
  input  logic last_byte,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic stop_pend,
  output logic stop_det
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       accept_ok, clr_evt, seq_go, hold_done;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_stop_detect u_det (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .det(stop_det)
  );

  i2c_stop_req u_req (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stop(wr_stop),
    .wr_start(wr_start), .wr_release(wr_release), .en(en),
    .wait_sel9(wait_sel9), .ack_en(ack_en), .is_master(is_master),
    .is_tx(is_tx), .arb_lost(arb_lost), .wait8_ph(wait8_ph),
    .wait9_ph(wait9_ph), .last_byte(last_byte), .bus_stop(stop_det),
    .accept_ok(accept_ok), .clr_evt(clr_evt), .go(seq_go), .pend(stop_pend)
  );

  i2c_stop_seq #(.HOLD_CLKS(HOLD_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(seq_go), .abort(clr_evt), .scl_hi(scl_s),
    .hold_done(hold_done), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );
endmodule

// File: rtl/i2c_stop_ctl_chk.sv
module i2c_stop_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_stop,
  input logic wr_start,
  input logic en,
  input logic ack_en,
  input logic is_master,
  input logic is_tx,
  input logic arb_lost,
  input logic wait9_ph,
  input logic last_byte,
  input logic scl_pull,
  input logic sda_pull,
  input logic stop_pend,
  input logic stop_det
);
  AST_SET_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_pend) |-> $past(is_master) && $past(en) && $past(wr_en && wr_stop)); // R1
  AST_NO_SET_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_pend) |-> !$past(wr_start)); // R2
  AST_TX_AFTER_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_pend) && $past(is_tx) |-> $past(wait9_ph)); // R3
  AST_RX_FINAL_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_pend) && !$past(is_tx) |-> !$past(ack_en) && $past(last_byte)); // R4
  AST_ARB_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !stop_pend && !scl_pull && !sda_pull); // R6
  AST_DISABLE_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !stop_pend && !scl_pull && !sda_pull); // R6
  AST_SDA_BEFORE_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> sda_pull); // R7
  AST_SCL_FREED_SDA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) && stop_pend |-> sda_pull); // R7
  AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !stop_det); // R9
endmodule

bind i2c_stop_ctl i2c_stop_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stop(wr_stop),
  .wr_start(wr_start), .en(en), .ack_en(ack_en), .is_master(is_master),
  .is_tx(is_tx), .arb_lost(arb_lost), .wait9_ph(wait9_ph),
  .last_byte(last_byte), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .stop_pend(stop_pend), .stop_det(stop_det)
);

// File: tb/i2c_stop_ctl_test.sv
module i2c_stop_ctl_test;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_stop = 0, wr_start = 0, wr_release = 0;
  logic en = 1, wait_sel9 = 1, ack_en = 0, is_master = 1, is_tx = 1;
  logic arb_lost = 0, wait8_ph = 0, wait9_ph = 0, last_byte = 0;
  logic ext_scl_low = 1, ext_sda_low = 0;
  logic scl_line, sda_line, scl_pull, sda_pull, stop_pend, stop_det;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign scl_line = ~(scl_pull | ext_scl_low);
  assign sda_line = ~(sda_pull | ext_sda_low);

  i2c_stop_ctl #(.HOLD_CLKS(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stop(wr_stop),
    .wr_start(wr_start), .wr_release(wr_release), .en(en),
    .wait_sel9(wait_sel9), .ack_en(ack_en), .is_master(is_master),
    .is_tx(is_tx), .arb_lost(arb_lost), .wait8_ph(wait8_ph),
    .wait9_ph(wait9_ph), .last_byte(last_byte), .scl_in(scl_line),
    .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .stop_pend(stop_pend), .stop_det(stop_det)
  );

  function automatic logic model_accept(logic e, logic m, logic st, logic p,
                                        logic tx, logic w8, logic w9,
                                        logic s9, logic ak, logic lb);
    logic ok_phase;
    if (!(e && m) || st || p) return 1'b0;
    if (tx) return w9;
    ok_phase = (w8 && !s9) || w9;
    return ok_phase && lb && !ak;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    wr_en = 0; wr_stop = 0; wr_start = 0; wr_release = 0;
    en = 1; wait_sel9 = 1; ack_en = 0; is_master = 1; is_tx = 1;
    arb_lost = 0; wait8_ph = 0; wait9_ph = 0; last_byte = 0;
  endtask

  task automatic write(input logic s, input logic st, input logic rel);
    wr_en = 1; wr_stop = s; wr_start = st; wr_release = rel;
    tick();
    wr_en = 0; wr_stop = 0; wr_start = 0; wr_release = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Full stop sequence in transmission, optional SCL stretch and repeat write.
  task automatic run_stop(input int stretch, input logic again);
    defaults(); wait9_ph = 1;
    write(1, 0, 0);
    chk("R7 pend on accept", stop_pend, 1);
    chk("R7 sda pulled first", sda_pull, 1);
    chk("R7 scl pulled at accept", scl_pull, 1);
    wait9_ph = 0;
    if (stretch == 0) ext_scl_low = 0;
    tick();
    chk("R7 scl freed", scl_pull, 0);
    chk("R7 sda still held", sda_pull, 1);
    if (stretch > 0) begin
      for (int i = 0; i < stretch; i++) tick();
      chk("R8 sda held while stretched", sda_pull, 1);
      ext_scl_low = 0;
    end
    for (int i = 1; i <= HOLD + 2; i++) begin
      if (again && i == 3) write(1, 0, 0);
      else tick();
    end
    chk("R8 sda held until hold done", sda_pull, 1);
    if (again) chk("R5 repeat write keeps pend", stop_pend, 1);
    tick();
    chk("R8 sda released after hold", sda_pull, 0);
    tick();
    chk("R9 no early det", stop_det, 0);
    tick();
    chk("R9 det pulse", stop_det, 1);
    chk("R6 pend held until det", stop_pend, 1);
    tick();
    chk("R9 det one cycle", stop_det, 0);
    chk("R6 pend cleared by det", stop_pend, 0);
    ext_scl_low = 1;
    repeat (4) tick();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    defaults();
    repeat (3) tick();
    chk("R10 scl_pull reset", scl_pull, 0);
    chk("R10 sda_pull reset", sda_pull, 0);
    chk("R10 pend reset", stop_pend, 0);
    chk("R10 det reset", stop_det, 0);
    rst_n = 1;
    repeat (4) tick();

    // Directed rejections
    defaults(); wait9_ph = 1; is_master = 0;
    write(1, 0, 0); chk("R1 slave write ignored", stop_pend, 0);
    defaults(); wait9_ph = 1;
    write(1, 1, 0); chk("R2 with start rejected", stop_pend, 0);
    defaults(); wait8_ph = 1; wait_sel9 = 0;
    write(1, 0, 0); chk("R3 tx eighth wait rejected", stop_pend, 0);
    defaults(); is_tx = 0; wait9_ph = 1; ack_en = 1; last_byte = 1;
    write(1, 0, 0); chk("R4 rx with ack rejected", stop_pend, 0);
    defaults(); is_tx = 0; wait8_ph = 1; wait_sel9 = 0; last_byte = 1;
    write(1, 0, 0); chk("R4 rx eighth wait accepted", stop_pend, 1);
    defaults(); write(0, 0, 1);
    chk("R6 release clears", stop_pend, 0);
    tick();

    // Clear events
    defaults(); wait9_ph = 1; write(1, 0, 0);
    defaults(); arb_lost = 1; tick(); arb_lost = 0;
    chk("R6 arb clears pend", stop_pend, 0);
    chk("R6 arb frees sda", sda_pull, 0);
    tick();
    defaults(); wait9_ph = 1; write(1, 0, 0);
    defaults(); en = 0; tick(); en = 1;
    chk("R6 disable clears pend", stop_pend, 0);
    chk("R6 disable frees scl", scl_pull, 0);
    tick();

    // Stop sequences
    run_stop(0, 0);
    run_stop(9, 0);
    run_stop(0, 1);

    // External stop from another master
    ext_sda_low = 1; repeat (3) tick();
    ext_scl_low = 0; repeat (4) tick();
    ext_sda_low = 0;
    tick(); chk("R9 ext no early det", stop_det, 0);
    tick(); chk("R9 ext det pulse", stop_det, 1);
    tick(); chk("R9 ext det one cycle", stop_det, 0);
    ext_scl_low = 1; repeat (4) tick();

    // Random acceptance
    for (int n = 0; n < 300; n++) begin
      logic exp, st;
      int ph;
      defaults();
      en = ($urandom % 8) != 0;
      is_master = ($urandom % 4) != 0;
      st = ($urandom % 6) == 0;
      is_tx = $urandom % 2;
      ph = $urandom % 3;
      wait8_ph = (ph == 1);
      wait9_ph = (ph == 2);
      wait_sel9 = $urandom % 2;
      ack_en = $urandom % 2;
      last_byte = $urandom % 2;
      exp = model_accept(en, is_master, st, 1'b0, is_tx, wait8_ph, wait9_ph,
                         wait_sel9, ack_en, last_byte);
      write(1, st, 0);
      chk("R1/R2/R3/R4 random accept", stop_pend, exp);
      if (exp) chk("R7 random sda pulled", sda_pull, 1);
      defaults();
      write(0, 0, 1);
      chk("R6 random release", stop_pend, 0);
      tick();
    end

    report();
  end
endmodule